// File: doc/BRIEF.md
# Command and Response Queue Level Interrupts

This block keeps the occupancy of two queues that sit between software and a bus controller engine and raises one interrupt per queue when a programmable level is reached. The command queue has 8 locations: software pushes commands and the engine pops them. The interrupt for this queue watches the number of free locations. The response queue has 4 locations: the engine pushes results and software pops them. Its interrupt watches the number of filled entries. Only the counts are kept here. The entry payloads live elsewhere.

Both levels come from a threshold register that software writes through a 16-bit port. It holds two byte lanes, and each lane carries one threshold. The two thresholds use different encodings. For the response queue, a value N means "N+1 or more entries". For the command queue, a value N from 1 to 7 means "N or more free locations", and a value of 0 means "every location free". Out-of-range writes are stored as the largest legal value. A push to a full queue or a pop from an empty queue is dropped and latches an error flag for that queue.

Top module: `queue_level_irq`

## Requirements
- R1: After a synchronous active-low reset, `cmd_free` = 8, `rsp_fill` = 0, `cmd_irq` = 1, `rsp_irq` = 0, both error flags are 0, and `thr_rdata` = 16'h0100 (response threshold 1, command threshold 0).
- R2: In a cycle where it is accepted, a command push lowers `cmd_free` by one at the next clock edge. An accepted command pop raises it by one. An accepted push and an accepted pop in the same cycle leave it unchanged.
- R3: In a cycle where it is accepted, a response push raises `rsp_fill` by one at the next clock edge. An accepted response pop lowers it by one. An accepted push and an accepted pop in the same cycle leave it unchanged.
- R4: A pop is accepted only if its queue holds at least one entry. A push is accepted if its queue is not full, or if a pop of the same queue is accepted in the same cycle. A rejected push or pop leaves the count unchanged and sets that queue's error flag (`cmd_err` or `rsp_err`) at the next edge.
- R5: An error flag, once set, stays at 1 until reset.
- R6: With a command threshold N from 1 to 7, `cmd_irq` is 1 exactly when `cmd_free` >= N.
- R7: With a command threshold of 0, `cmd_irq` is 1 exactly when `cmd_free` = 8.
- R8: With a response threshold N from 0 to 3, `rsp_irq` is 1 exactly when `rsp_fill` >= N+1.
- R9: When `thr_we` is high at a clock edge, `thr_wdata[7:0]` becomes the command threshold and `thr_wdata[15:8]` becomes the response threshold. `thr_rdata` returns the stored command threshold in bits 7:0 and the stored response threshold in bits 15:8, with all other bits 0.
- R10: A command threshold write above 7 is stored as 7. A response threshold write above 3 is stored as 3.
- R11: Each interrupt follows the current counts and thresholds without extra delay. It changes in the same cycle in which a count or a threshold takes its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 16 | Threshold write data: command level in [7:0], response level in [15:8] |
| thr_rdata | output | 16 | Stored thresholds, same layout as the write data |
| cmd_push | input | 1 | Software places one command |
| cmd_pop | input | 1 | Engine takes one command |
| rsp_push | input | 1 | Engine places one response |
| rsp_pop | input | 1 | Software takes one response |
| cmd_free | output | 4 | Free command locations (0 to 8) |
| rsp_fill | output | 3 | Filled response entries (0 to 4) |
| cmd_irq | output | 1 | Command queue level interrupt |
| rsp_irq | output | 1 | Response queue level interrupt |
| cmd_err | output | 1 | Sticky command queue push/pop error |
| rsp_err | output | 1 | Sticky response queue push/pop error |

## Verification
A push and a pop of the same queue can arrive in the same cycle. The case that matters is a full or empty queue, where acceptance of one strobe depends on the other. The bench drives biased random strobes so that both queues spend long stretches full and long stretches empty, and it often raises both strobes together. Every cycle it compares the counts, the error flags and both interrupts against a behavioural model that applies the acceptance rule on its own. A threshold write can also land in a cycle where a count changes. Such writes are issued during live traffic, and the interrupt is judged against the new threshold and the new count together on the following cycle.

// File: rtl/qthr_pkg.sv
// Shared constants for the queue level interrupt block.
// Assumes both thresholds sit in byte-wide lanes of the threshold register.
package qthr_pkg;

    localparam int FLD_W       = 8;   // width of one threshold lane
    localparam int CMD_FLD_LSB = 0;   // command threshold lane position
    localparam int RSP_FLD_LSB = 8;   // response threshold lane position
    localparam int REG_W       = 16;  // bits of the register held here

    // How a comparator reads its threshold.
    typedef enum logic {
        CMP_FREE_SLOTS = 1'b0,  // N>0: free >= N, N=0: queue fully empty
        CMP_FILL_PLUS1 = 1'b1   // fill >= N+1
    } cmp_mode_e;

endpackage

// File: rtl/qlvl_counter.sv
// Occupancy counter for one queue with push/pop acceptance and a sticky error.
// Assumes push and pop are single-cycle strobes; payload storage lives elsewhere.
module qlvl_counter #(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [LW-1:0] occ,
    output logic          err
);

    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic pop_ok;
    logic push_ok;
    logic bad;

    // Acceptance: pop needs data, push needs room or a same-cycle pop.
    always_comb begin
        pop_ok  = pop && (occ != '0);
        push_ok = push && ((occ != FULL) || pop_ok);
        bad     = (pop && !pop_ok) || (push && !push_ok);
    end

    // Occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else if (bad) err <= 1'b1;
    end

endmodule

// File: rtl/qthr_cfg.sv
// Threshold register: two byte lanes, each clamped to its legal maximum on write.
// Assumes software writes both lanes together through one strobe.
module qthr_cfg
    import qthr_pkg::*;
#(
    parameter int CMD_TW  = 3,
    parameter int RSP_TW  = 2,
    parameter int CMD_RST = 0,
    parameter int RSP_RST = 1,
    localparam logic [FLD_W-1:0] CMD_MAX = FLD_W'((1 << CMD_TW) - 1),
    localparam logic [FLD_W-1:0] RSP_MAX = FLD_W'((1 << RSP_TW) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic [CMD_TW-1:0] cmd_thr,
    output logic [RSP_TW-1:0] rsp_thr,
    output logic [REG_W-1:0]  rdata
);

    logic [FLD_W-1:0] cmd_in;
    logic [FLD_W-1:0] rsp_in;
    logic [FLD_W-1:0] cmd_cl;
    logic [FLD_W-1:0] rsp_cl;

    // Split the write lanes and clamp each to its maximum.
    always_comb begin
        cmd_in = wdata[CMD_FLD_LSB +: FLD_W];
        rsp_in = wdata[RSP_FLD_LSB +: FLD_W];
        cmd_cl = (cmd_in > CMD_MAX) ? CMD_MAX : cmd_in;
        rsp_cl = (rsp_in > RSP_MAX) ? RSP_MAX : rsp_in;
    end

    // Threshold storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_thr <= CMD_TW'(CMD_RST);
            rsp_thr <= RSP_TW'(RSP_RST);
        end else if (we) begin
            cmd_thr <= cmd_cl[CMD_TW-1:0];
            rsp_thr <= rsp_cl[RSP_TW-1:0];
        end
    end

    // Readback with unused bits at zero.
    always_comb begin
        rdata = '0;
        rdata[CMD_FLD_LSB +: CMD_TW] = cmd_thr;
        rdata[RSP_FLD_LSB +: RSP_TW] = rsp_thr;
    end

endmodule

// File: rtl/qthr_cmp.sv
// Level comparator; the mode parameter picks the threshold encoding.
// Assumes the threshold is narrower than or equal to the level width.
module qthr_cmp
    import qthr_pkg::*;
#(
    parameter cmp_mode_e MODE  = CMP_FILL_PLUS1,
    parameter int        DEPTH = 4,
    localparam int       LW    = $clog2(DEPTH + 1),
    localparam int       TW    = $clog2(DEPTH)
) (
    input  logic [LW-1:0] lvl,
    input  logic [TW-1:0] thr,
    output logic          hit
);

    logic [LW-1:0] thr_x;

    // Widen the threshold to the level width.
    always_comb thr_x = LW'(thr);

    generate
        if (MODE == CMP_FREE_SLOTS) begin : g_free
            // Zero means every slot free, otherwise at least N free.
            always_comb hit = (thr_x == '0) ? (lvl == LW'(DEPTH)) : (lvl >= thr_x);
        end else begin : g_fill
            // At least N+1 entries present.
            always_comb hit = (lvl > thr_x);
        end
    endgenerate

endmodule

// File: rtl/queue_level_irq.sv
// Top: command/response queue occupancy with threshold interrupts.
// Assumes the command queue reports free locations and the response queue
// filled entries; interrupts are unmasked level outputs.
module queue_level_irq
    import qthr_pkg::*;
#(
    parameter int CMD_DEPTH = 8,
    parameter int RSP_DEPTH = 4,
    localparam int CLW = $clog2(CMD_DEPTH + 1),
    localparam int RLW = $clog2(RSP_DEPTH + 1),
    localparam int CTW = $clog2(CMD_DEPTH),
    localparam int RTW = $clog2(RSP_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [REG_W-1:0] thr_wdata,
    output logic [REG_W-1:0] thr_rdata,
    input  logic             cmd_push,
    input  logic             cmd_pop,
    input  logic             rsp_push,
    input  logic             rsp_pop,
    output logic [CLW-1:0]   cmd_free,
    output logic [RLW-1:0]   rsp_fill,
    output logic             cmd_irq,
    output logic             rsp_irq,
    output logic             cmd_err,
    output logic             rsp_err
);

    logic [CLW-1:0] cmd_occ;
    logic [CTW-1:0] cmd_thr;
    logic [RTW-1:0] rsp_thr;

    qthr_cfg #(
        .CMD_TW (CTW),
        .RSP_TW (RTW),
        .CMD_RST(0),
        .RSP_RST(1)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (thr_we),
        .wdata  (thr_wdata),
        .cmd_thr(cmd_thr),
        .rsp_thr(rsp_thr),
        .rdata  (thr_rdata)
    );

    qlvl_counter #(.DEPTH(CMD_DEPTH)) u_cmd_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .push (cmd_push),
        .pop  (cmd_pop),
        .occ  (cmd_occ),
        .err  (cmd_err)
    );

    qlvl_counter #(.DEPTH(RSP_DEPTH)) u_rsp_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rsp_push),
        .pop  (rsp_pop),
        .occ  (rsp_fill),
        .err  (rsp_err)
    );

    // Free command locations from occupancy.
    always_comb cmd_free = CLW'(CMD_DEPTH) - cmd_occ;

    qthr_cmp #(.MODE(CMP_FREE_SLOTS), .DEPTH(CMD_DEPTH)) u_cmd_cmp (
        .lvl(cmd_free),
        .thr(cmd_thr),
        .hit(cmd_irq)
    );

    qthr_cmp #(.MODE(CMP_FILL_PLUS1), .DEPTH(RSP_DEPTH)) u_rsp_cmp (
        .lvl(rsp_fill),
        .thr(rsp_thr),
        .hit(rsp_irq)
    );

endmodule

// File: rtl/qthr_chk.sv
// Checker for queue_level_irq, attached by bind; observes ports only.
module qthr_chk
    import qthr_pkg::*;
#(
    parameter int CMD_DEPTH = 8,
    parameter int RSP_DEPTH = 4,
    localparam int CLW = $clog2(CMD_DEPTH + 1),
    localparam int RLW = $clog2(RSP_DEPTH + 1),
    localparam int CTW = $clog2(CMD_DEPTH),
    localparam int RTW = $clog2(RSP_DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             thr_we,
    input logic [REG_W-1:0] thr_wdata,
    input logic [REG_W-1:0] thr_rdata,
    input logic             cmd_push,
    input logic             cmd_pop,
    input logic             rsp_push,
    input logic             rsp_pop,
    input logic [CLW-1:0]   cmd_free,
    input logic [RLW-1:0]   rsp_fill,
    input logic             cmd_irq,
    input logic             rsp_irq,
    input logic             cmd_err,
    input logic             rsp_err
);

    // R4
    cmd_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_push && !cmd_pop && cmd_free == '0) |=> ($stable(cmd_free) && cmd_err));

    // R4
    rsp_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_pop && !rsp_push && rsp_fill == '0) |=> ($stable(rsp_fill) && rsp_err));

    // R5
    cmd_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R5
    rsp_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> rsp_err);

    // R7
    cmd_zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_irq && thr_rdata[CMD_FLD_LSB +: FLD_W] == '0) |-> (cmd_free == CLW'(CMD_DEPTH)));

    // R8
    rsp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_irq |-> (RLW'(thr_rdata[RSP_FLD_LSB +: RTW]) < rsp_fill));

    // R10
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_rdata[CMD_FLD_LSB +: FLD_W] < FLD_W'(CMD_DEPTH)) &&
        (thr_rdata[RSP_FLD_LSB +: FLD_W] < FLD_W'(RSP_DEPTH)));

    // R2
    cmd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_free <= CLW'(CMD_DEPTH));

    // R3
    rsp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fill <= RLW'(RSP_DEPTH));

endmodule

bind queue_level_irq qthr_chk #(.CMD_DEPTH(CMD_DEPTH), .RSP_DEPTH(RSP_DEPTH)) u_qthr_chk (.*);

// File: tb/test_queue_level_irq.sv
module test_queue_level_irq;

    localparam int CLK_P = 10;
    localparam int CDEP  = 8;
    localparam int RDEP  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        thr_we = 1'b0;
    logic [15:0] thr_wdata = '0;
    logic [15:0] thr_rdata;
    logic        cmd_push = 1'b0, cmd_pop = 1'b0, rsp_push = 1'b0, rsp_pop = 1'b0;
    logic [3:0]  cmd_free;
    logic [2:0]  rsp_fill;
    logic        cmd_irq, rsp_irq, cmd_err, rsp_err;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cfree, m_rfill, m_cthr, m_rthr;
    bit m_cerr, m_rerr;

    always #(CLK_P/2) clk = ~clk;

    queue_level_irq i_queue_level_irq (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model update at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfree = CDEP; m_rfill = 0; m_cthr = 0; m_rthr = 1;
            m_cerr = 0; m_rerr = 0;
        end else begin
            bit pok, uok;
            if (thr_we) begin
                m_cthr = (thr_wdata[7:0]  > 7) ? 7 : int'(thr_wdata[7:0]);
                m_rthr = (thr_wdata[15:8] > 3) ? 3 : int'(thr_wdata[15:8]);
            end
            pok = cmd_pop && (m_cfree < CDEP);
            uok = cmd_push && (m_cfree > 0 || pok);
            if ((cmd_pop && !pok) || (cmd_push && !uok)) m_cerr = 1;
            m_cfree = m_cfree - int'(uok) + int'(pok);
            pok = rsp_pop && (m_rfill > 0);
            uok = rsp_push && (m_rfill < RDEP || pok);
            if ((rsp_pop && !pok) || (rsp_push && !uok)) m_rerr = 1;
            m_rfill = m_rfill + int'(uok) - int'(pok);
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (live && rst_n) begin
            bit ce;
            ce = (m_cthr == 0) ? (m_cfree == CDEP) : (m_cfree >= m_cthr);
            chk(cmd_free == m_cfree, "R2", cmd_free, m_cfree);
            chk(rsp_fill == m_rfill, "R3", rsp_fill, m_rfill);
            chk(cmd_err == m_cerr, "R4/R5 cmd", cmd_err, m_cerr);
            chk(rsp_err == m_rerr, "R4/R5 rsp", rsp_err, m_rerr);
            if (m_cthr == 0) chk(cmd_irq == ce, "R7/R11", cmd_irq, ce);
            else             chk(cmd_irq == ce, "R6/R11", cmd_irq, ce);
            chk(rsp_irq == (m_rfill >= m_rthr + 1), "R8/R11", rsp_irq, m_rfill >= m_rthr + 1);
            chk(thr_rdata == 16'((m_rthr << 8) | m_cthr), "R9/R10", thr_rdata, (m_rthr << 8) | m_cthr);
        end
    end

    task automatic traffic(input int n, input int cpu, input int cpo, input int rpu, input int rpo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_push = ($urandom_range(99) < cpu);
            cmd_pop  = ($urandom_range(99) < cpo);
            rsp_push = ($urandom_range(99) < rpu);
            rsp_pop  = ($urandom_range(99) < rpo);
            // occasional threshold write during live traffic
            thr_we   = ($urandom_range(99) < 3);
            thr_wdata = 16'($urandom_range(65535));
        end
        @(negedge clk);
        {cmd_push, cmd_pop, rsp_push, rsp_pop, thr_we} = '0;
    endtask

    task automatic wr_thr(input logic [7:0] rv, input logic [7:0] cv);
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = {rv, cv};
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    initial begin
        logic [7:0] cvals[12] = '{8'd0, 8'd1, 8'd4, 8'd7, 8'd8, 8'hFF, 8'd3, 8'd0, 8'd6, 8'd2, 8'd5, 8'd9};
        logic [7:0] rvals[12] = '{8'd0, 8'd3, 8'd2, 8'd4, 8'hFF, 8'd1, 8'd0, 8'd2, 8'd3, 8'd1, 8'd0, 8'd7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_free == 8, "R1 cmd_free", cmd_free, 8);
        chk(rsp_fill == 0, "R1 rsp_fill", rsp_fill, 0);
        chk(cmd_irq == 1, "R1 cmd_irq", cmd_irq, 1);
        chk(rsp_irq == 0, "R1 rsp_irq", rsp_irq, 0);
        chk(cmd_err == 0 && rsp_err == 0, "R1 err", {cmd_err, rsp_err}, 0);
        chk(thr_rdata == 16'h0100, "R1 thr", thr_rdata, 16'h0100);
        live = 1'b1;
        for (int p = 0; p < 12; p++) begin
            wr_thr(rvals[p], cvals[p]);
            // R10 clamp visible right after the write
            @(negedge clk);
            chk(thr_rdata[7:0] == ((cvals[p] > 7) ? 8'd7 : cvals[p]), "R10 cmd", thr_rdata[7:0], cvals[p]);
            chk(thr_rdata[15:8] == ((rvals[p] > 3) ? 8'd3 : rvals[p]), "R10 rsp", thr_rdata[15:8], rvals[p]);
            traffic(60, 80, 20, 80, 20);   // fill up, push into full
            traffic(60, 60, 60, 60, 60);   // dense simultaneous strobes
            traffic(60, 20, 80, 20, 80);   // drain, pop from empty
            if (p == 6) begin
                // R5: only reset clears the sticky flags
                chk(cmd_err == 1 && rsp_err == 1, "R5 set", {cmd_err, rsp_err}, 3);
                @(negedge clk); rst_n = 1'b0;
                @(negedge clk); rst_n = 1'b1;
                @(negedge clk);
                chk(cmd_err == 0 && rsp_err == 0, "R5 cleared", {cmd_err, rsp_err}, 0);
            end
        end
        live = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule